// File: doc/BRIEF.md
# Single-Slope Converter Timer and Capture Unit

This block is the digital timing side of a single-slope analog-to-digital converter. A 16-bit timer counts enabled clock ticks while an off-chip ramp rises. When the ramp crosses the input, the comparator output drops from high to low. That falling edge latches the running count into a capture register, and the captured count is the conversion result. If the timer wraps around before the comparator trips, an overflow flag is raised, and the timer keeps counting.

Software reaches the block through a byte-wide register port. It can load and read the timer, read the capture, clear or set the two flags, program the interrupt enables and drive the ramp controls. The ramp controls are a 4-bit current code, a discharge bit and a shutdown bit. Raising and then releasing the discharge bit starts a new conversion. The comparator arrives asynchronously and passes through a two-flop synchronizer.

The register map is:
- 0: timer high byte
- 1: timer low byte
- 2: capture high byte (read only)
- 3: capture low byte (read only)
- 4: control, with [7:4] ramp code, [1] discharge, [0] shutdown
- 5: flags, with [1] capture, [0] overflow
- 6: interrupt enables, with [3] global, [2] peripheral, [1] capture, [0] overflow

Top module: `slope_capture_unit`

## Requirements
- R1: After reset, control reads 03h, flags, timer and capture read 00h, irq is 0 and ramp_en is 0.
- R2: While the timer runs, shutdown (control[0]) is 0 and the selected tick is 1, the timer advances by one per clock. Going from FFFFh it wraps to 0000h, sets flag bit 0 (overflow) and keeps counting.
- R3: A write to address 0 loads the high byte and stops the timer. A following write to address 1 loads the low byte and starts the timer. A low-byte write without a high-byte write just before it leaves the timer stopped.
- R4: With cfg_ext_clk=1 only ext_tick advances the timer; with cfg_ext_clk=0 only int_tick does. With shutdown=1 the timer holds.
- R5: A high-to-low change on comp_in copies the timer into the capture register (addresses 2/3) and sets flag bit 1 (capture). The copy happens on the third rising clock edge after comp_in is low.
- R6: After a capture, further comparator falls are ignored until control[1] (discharge) goes from 1 to 0.
- R7: ramp_en equals the inverse of control[1], and ramp_code equals control[7:4].
- R8: irq is 1 only when enable[3] and enable[2] are both 1 and some flag is 1 together with its own enable (bit 1 for capture, bit 0 for overflow).
- R9: Flags are never cleared by hardware. A write to address 5 loads bits [1:0]. A hardware set in the same cycle as a written 0 leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ext_clk | input | 1 | Static tick source select: 1 = external, 0 = internal |
| ext_tick | input | 1 | External oscillator tick enable |
| int_tick | input | 1 | Internal oscillator tick enable |
| comp_in | input | 1 | Asynchronous comparator output, falls when the ramp passes the input |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| ramp_en | output | 1 | Ramp current source enable |
| ramp_code | output | 4 | Ramp current magnitude code |

## Verification
The bench targets the write ordering: a lone low-byte write must not start the timer, so a design that ignores the order would show a moving count where a frozen one is expected. It checks the wrap from FFFFh to 0001h after three ticks, which catches both a saturating counter and one that halts on overflow. It also checks the exact capture latency and the once-per-conversion lockout with its re-arm on the discharge release; a missing lockout would overwrite the first result. Finally it aligns a capture with a software write of 0 to the flags, where a design that lets software win would lose the capture flag.

// File: rtl/slope_cap_pkg.sv
package slope_cap_pkg;
    localparam int BYTE_W = 8;
    localparam int TMR_W  = 2 * BYTE_W;
    localparam int CODE_W = 4;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_TMR_HI = 3'd0,
        A_TMR_LO = 3'd1,
        A_CAP_HI = 3'd2,
        A_CAP_LO = 3'd3,
        A_CTRL   = 3'd4,
        A_FLAGS  = 3'd5,
        A_IEN    = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [1:0]        spare;
        logic              discharge;
        logic              shutdown;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] spare;
        logic       glb;
        logic       per;
        logic       cap_ie;
        logic       ovf_ie;
    } ien_t;

    localparam ctrl_t CTRL_RST = '{code: '0, spare: '0, discharge: 1'b1, shutdown: 1'b1};

    function automatic logic [BYTE_W-1:0] hi_byte(input logic [TMR_W-1:0] v);
        return v[TMR_W-1:BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] lo_byte(input logic [TMR_W-1:0] v);
        return v[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/slope_cap_sync.sv
module slope_cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b1;
        else     last <= chain[STAGES-1];
    end

    assign fall_o = last & ~chain[STAGES-1];

    // R5: an edge is reported for one cycle only
    p_fall_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);
endmodule

// File: rtl/slope_cap_timer.sv
module slope_cap_timer
    import slope_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              hi_we,
    input  logic              lo_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [TMR_W-1:0]  tmr_o,
    output logic              wrap_o
);
    logic run_q, hi_seen_q;
    logic step;

    assign step   = run_q & tick_en & ~hi_we & ~lo_we;
    assign wrap_o = step & (tmr_o == {TMR_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_o     <= '0;
            run_q     <= 1'b0;
            hi_seen_q <= 1'b0;
        end else if (hi_we) begin
            tmr_o[TMR_W-1:BYTE_W] <= wdata;
            run_q                 <= 1'b0;
            hi_seen_q             <= 1'b1;
        end else if (lo_we) begin
            tmr_o[BYTE_W-1:0] <= wdata;
            run_q             <= hi_seen_q;
            hi_seen_q         <= 1'b0;
        end else if (step) begin
            tmr_o <= tmr_o + 1'b1;
        end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        step |=> tmr_o == TMR_W'($past(tmr_o) + 1'b1));
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !hi_we && !lo_we) |=> $stable(tmr_o));
    p_lo_alone_r3: assert property (@(posedge clk) disable iff (rst)
        (lo_we && !hi_seen_q && !hi_we) |=> !run_q);
endmodule

// File: rtl/slope_cap_flag.sv
module slope_cap_flag (
    input  logic clk,
    input  logic rst,
    input  logic hw_set,
    input  logic sw_we,
    input  logic sw_val,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (sw_we) flag_q <= sw_val | hw_set;
        else            flag_q <= flag_q | hw_set;
    end

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !sw_we) |=> flag_q);
    p_hw_wins_r9: assert property (@(posedge clk) disable iff (rst)
        hw_set |=> flag_q);
endmodule

// File: rtl/slope_capture_unit.sv
module slope_capture_unit
    import slope_cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ext_clk,
    input  logic              ext_tick,
    input  logic              int_tick,
    input  logic              comp_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    output logic [CODE_W-1:0] ramp_code,
    output logic              ramp_en
);
    ctrl_t            ctrl_q;
    ien_t             ien_q;
    logic [TMR_W-1:0] tmr, cap_q;
    logic             locked_q, dis_prev_q;
    logic             fall, fire, rearm, wrap, tick_sel;
    logic             cap_flag, ovf_flag, flag_we;
    reg_addr_e        a;

    assign a        = reg_addr_e'(reg_addr);
    assign tick_sel = (cfg_ext_clk ? ext_tick : int_tick) & ~ctrl_q.shutdown;
    assign rearm    = dis_prev_q & ~ctrl_q.discharge;
    assign fire     = fall & ~locked_q;
    assign flag_we  = reg_we && a == A_FLAGS;

    slope_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(comp_in), .fall_o(fall));

    slope_cap_timer u_timer (
        .clk(clk), .rst(rst), .tick_en(tick_sel),
        .hi_we(reg_we && a == A_TMR_HI), .lo_we(reg_we && a == A_TMR_LO),
        .wdata(reg_wdata), .tmr_o(tmr), .wrap_o(wrap));

    slope_cap_flag u_cap_flag (
        .clk(clk), .rst(rst), .hw_set(fire), .sw_we(flag_we),
        .sw_val(reg_wdata[1]), .flag_q(cap_flag));

    slope_cap_flag u_ovf_flag (
        .clk(clk), .rst(rst), .hw_set(wrap), .sw_we(flag_we),
        .sw_val(reg_wdata[0]), .flag_q(ovf_flag));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= CTRL_RST;
            ien_q      <= '0;
            cap_q      <= '0;
            locked_q   <= 1'b0;
            dis_prev_q <= 1'b1;
        end else begin
            dis_prev_q <= ctrl_q.discharge;
            if (reg_we && a == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
            if (reg_we && a == A_IEN)  ien_q  <= ien_t'(reg_wdata);
            if (fire) cap_q <= tmr;
            if (rearm)     locked_q <= 1'b0;
            else if (fire) locked_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (a)
            A_TMR_HI: reg_rdata = hi_byte(tmr);
            A_TMR_LO: reg_rdata = lo_byte(tmr);
            A_CAP_HI: reg_rdata = hi_byte(cap_q);
            A_CAP_LO: reg_rdata = lo_byte(cap_q);
            A_CTRL:   reg_rdata = ctrl_q;
            A_FLAGS:  reg_rdata = {6'd0, cap_flag, ovf_flag};
            A_IEN:    reg_rdata = ien_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq       = ien_q.glb & ien_q.per &
                       ((cap_flag & ien_q.cap_ie) | (ovf_flag & ien_q.ovf_ie));
    assign ramp_en   = ~ctrl_q.discharge;
    assign ramp_code = ctrl_q.code;

    p_lockout_r6: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> $stable(cap_q));
    p_capture_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (cap_q != $past(cap_q)) |-> cap_flag);
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_q.glb && ien_q.per && (cap_flag || ovf_flag)));
endmodule

// File: tb/test_slope_capture_unit.sv
module test_slope_capture_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_ext_clk = 1'b0, ext_tick = 1'b0, int_tick = 1'b1, comp_in = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       irq, ramp_en;
    logic [3:0] ramp_code;
    int checks = 0, fails = 0;

    localparam logic [2:0] T_HI = 3'd0, T_LO = 3'd1, C_HI = 3'd2, C_LO = 3'd3,
                           CTRL = 3'd4, FLG = 3'd5, IEN = 3'd6;

    always #5 clk = ~clk;

    slope_capture_unit i_slope_capture_unit (
        .clk(clk), .rst(rst), .cfg_ext_clk(cfg_ext_clk), .ext_tick(ext_tick),
        .int_tick(int_tick), .comp_in(comp_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .ramp_code(ramp_code), .ramp_en(ramp_en));

    // vector: [19] read(1)/write(0), [18:16] address, [15:8] data or expected, [3:0] requirement
    localparam int NV = 15;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, CTRL, 8'h03, 8'd1},   // R1
        {1'b1, FLG,  8'h00, 8'd1},   // R1
        {1'b1, T_HI, 8'h00, 8'd1},   // R1
        {1'b1, C_LO, 8'h00, 8'd1},   // R1
        {1'b0, CTRL, 8'h50, 8'd0},
        {1'b0, T_LO, 8'h34, 8'd0},
        {1'b1, T_LO, 8'h34, 8'd3},   // R3 lone low write: frozen
        {1'b1, T_HI, 8'h00, 8'd3},   // R3
        {1'b0, CTRL, 8'h51, 8'd0},
        {1'b0, T_HI, 8'h12, 8'd0},
        {1'b0, T_LO, 8'h34, 8'd0},
        {1'b0, CTRL, 8'h50, 8'd0},
        {1'b0, CTRL, 8'h51, 8'd0},
        {1'b1, T_LO, 8'h35, 8'd2},   // R2 one step
        {1'b1, T_HI, 8'h12, 8'd2}    // R2
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] ad, input logic [7:0] d);
        reg_addr = ad; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] ad, input logic [7:0] exp);
        reg_addr = ad; #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", {7'd0, irq}, 8'h00);
        chk("R1", {7'd0, ramp_en}, 8'h00);
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) rd($sformatf("R%0d", VEC[i][3:0]), VEC[i][18:16], VEC[i][15:8]);
            else            wr(VEC[i][18:16], VEC[i][15:8]);
        end

        // R4 tick select and shutdown
        cfg_ext_clk = 1'b1; ext_tick = 1'b0;
        wr(CTRL, 8'h50); idle(3); wr(CTRL, 8'h51);
        rd("R4", T_LO, 8'h35);
        ext_tick = 1'b1;
        wr(CTRL, 8'h50); idle(1); wr(CTRL, 8'h51);
        rd("R4", T_LO, 8'h37);
        idle(5);
        rd("R4", T_LO, 8'h37);

        // R2 wrap, overflow flag, keeps counting
        wr(FLG, 8'h00);
        wr(T_HI, 8'hFF); wr(T_LO, 8'hFE);
        wr(CTRL, 8'h50); idle(2); wr(CTRL, 8'h51);
        rd("R2", T_HI, 8'h00);
        rd("R2", T_LO, 8'h01);
        rd("R2", FLG, 8'h01);
        idle(4);
        rd("R9", FLG, 8'h01);

        // R7 ramp outputs
        chk("R7", {7'd0, ramp_en}, 8'h01);
        chk("R7", {4'd0, ramp_code}, 8'h05);
        wr(CTRL, 8'h53);
        chk("R7", {7'd0, ramp_en}, 8'h00);
        wr(CTRL, 8'hA1);
        chk("R7", {7'd0, ramp_en}, 8'h01);
        chk("R7", {4'd0, ramp_code}, 8'h0A);

        // R5 capture value and latency (timer frozen by shutdown)
        wr(T_HI, 8'h5A); wr(T_LO, 8'hC3); wr(FLG, 8'h00);
        comp_in = 1'b0;
        idle(2);
        rd("R5", C_LO, 8'h00);
        idle(1);
        rd("R5", C_LO, 8'hC3);
        rd("R5", C_HI, 8'h5A);
        rd("R5", FLG, 8'h02);

        // R6 lockout until discharge release
        comp_in = 1'b1; idle(3);
        wr(T_HI, 8'h11); wr(T_LO, 8'h22);
        comp_in = 1'b0; idle(4);
        rd("R6", C_LO, 8'hC3);
        wr(CTRL, 8'hA3); wr(CTRL, 8'hA1);
        comp_in = 1'b1; idle(3);
        comp_in = 1'b0; idle(4);
        rd("R6", C_LO, 8'h22);
        rd("R6", C_HI, 8'h11);

        // R9 software writes and hardware-wins collision
        wr(FLG, 8'h00);
        rd("R9", FLG, 8'h00);
        wr(CTRL, 8'hA3); wr(CTRL, 8'hA1);
        comp_in = 1'b1; idle(3);
        comp_in = 1'b0; idle(2);
        wr(FLG, 8'h00);
        rd("R9", FLG, 8'h02);
        wr(FLG, 8'h01);
        rd("R9", FLG, 8'h01);

        // R8 interrupt gating
        wr(FLG, 8'h02);
        wr(IEN, 8'h02);
        chk("R8", {7'd0, irq}, 8'h00);
        wr(IEN, 8'h0E);
        chk("R8", {7'd0, irq}, 8'h01);
        wr(IEN, 8'h0A);
        chk("R8", {7'd0, irq}, 8'h00);
        wr(IEN, 8'h0D);
        chk("R8", {7'd0, irq}, 8'h00);
        wr(FLG, 8'h01);
        chk("R8", {7'd0, irq}, 8'h01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule